// File: doc/BRIEF.md
# Shared Multi-Queue Pointer Manager

This block keeps a set of independent linked-list queues of descriptor pointers for several bus masters that share it. A master adds an entry by writing a pointer to a queue's tail or head register. It removes the front entry by reading that queue's head register. It learns how full a queue is by reading that queue's status register. All queues chain their entries through one internal next-pointer RAM. The RAM is indexed by the pointer value itself, so a pointer may sit in at most one queue at a time. Pointer value 0 is reserved as the null pointer.

Each master presents a request with a valid/ready handshake. A round-robin arbiter accepts one request per cycle, and any other requester is held until it is accepted. Every push and pop is therefore a single indivisible update of that queue's head, tail and count. A read returns its data on the cycle after acceptance, flagged on that master's response-valid bit. Writes produce no response.

Top module: `qm_queue_manager`

## Requirements
- R1: A request address is `{queue index, select}`, with the select in the two low bits. The select codes are 0 (tail register), 1 (head register) and 2 (status register). A write to select 0 pushes at the tail. A write to select 1 pushes at the head. A read of select 1 pops. A read of select 2 returns status. A write to select 2 or 3 changes nothing. A read of select 0 or 3 returns 0 and changes nothing.
- R2: Pointers pushed at the tail of a queue are popped in the order they were pushed.
- R3: Pointers pushed at the head of a queue are popped in the reverse of the order they were pushed.
- R4: A pop returns the current front pointer and removes it. Head and tail pushes may be mixed on one queue, and the pop order follows from where each entry was inserted. Read data appears with `r_valid` set on the cycle after the request is accepted.
- R5: A pop of an empty queue returns 0 and leaves that queue empty.
- R6: A status read returns the entry count in bits [PTR_W-1:0] and an empty flag in bit PTR_W (1 when the count is 0). The status reflects every operation accepted in earlier cycles.
- R7: A push of pointer 0, at either end, is ignored, and the queue's count is unchanged.
- R8: At most one request is accepted per cycle. `m_ready` is only ever set for a master whose `m_valid` is set. Every accepted read produces exactly one response, and no update is lost under contention.
- R9: Arbitration is round-robin. A master that was accepted in the previous grant is passed over whenever another master is requesting.
- R10: An operation on one queue does not change the contents or count of any other queue.
- R11: After reset every queue is empty with count 0, and `r_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| m_valid | input | NUM_M | Request valid, one bit per master |
| m_write | input | NUM_M | 1 = write (push), 0 = read, per master |
| m_addr | input | NUM_M*(QID_W+2) | Per-master address `{queue, select}` |
| m_wdata | input | NUM_M*PTR_W | Per-master pointer to push |
| m_ready | output | NUM_M | Request accepted this cycle |
| r_valid | output | NUM_M | Read data valid for this master |
| r_data | output | PTR_W+1 | Read data: popped pointer or status word |

## Verification
The hardest state to reach is two masters contending in the same cycles for the same few queues. Under contention, pops and head pushes must interleave with tail pushes while entries are being relinked through the shared RAM. Two concurrent random drivers target only four queues and draw pointers from one shared free pool, so collisions and relinking are frequent. The reference model applies each operation at the moment the handshake accepts it, so the expected pop order follows the real grant order. Directed passes beforehand cover the null pointer, empty pops and unused register selects.

// File: rtl/qm_pkg.sv
package qm_pkg;

  typedef enum logic [2:0] {
    QOP_IDLE,
    QOP_PUSH_TAIL,
    QOP_PUSH_HEAD,
    QOP_POP,
    QOP_STATUS,
    QOP_NULL_RD
  } qop_e;

  localparam logic [1:0] SEL_TAIL = 2'd0;
  localparam logic [1:0] SEL_HEAD = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;

  function automatic qop_e qop_decode(logic vld, logic wr, logic [1:0] sel);
    if (!vld) return QOP_IDLE;
    if (wr) begin
      case (sel)
        SEL_TAIL: return QOP_PUSH_TAIL;
        SEL_HEAD: return QOP_PUSH_HEAD;
        default:  return QOP_IDLE;
      endcase
    end
    case (sel)
      SEL_HEAD: return QOP_POP;
      SEL_STAT: return QOP_STATUS;
      default:  return QOP_NULL_RD;
    endcase
  endfunction

  function automatic logic qop_is_read(qop_e op);
    return (op == QOP_POP) || (op == QOP_STATUS) || (op == QOP_NULL_RD);
  endfunction

endpackage

// File: rtl/qm_rr_arbiter.sv
module qm_rr_arbiter #(
  parameter int N = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);

  logic [IW-1:0] last_q;
  logic [IW-1:0] gnt_idx;

  function automatic logic [IW-1:0] onehot_index(logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++) if (v[i]) r = IW'(i);
    return r;
  endfunction

  always_comb begin
    logic found;
    int   idx;
    gnt   = '0;
    found = 1'b0;
    for (int k = 1; k <= N; k++) begin
      idx = (int'(last_q) + k) % N;
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  assign gnt_idx = onehot_index(gnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    last_q <= IW'(N - 1);
    else if (|gnt) last_q <= gnt_idx;
  end

  a_r8_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  a_r8_no_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> (gnt != '0));
  a_r9_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0 && gnt == $past(gnt)) |-> ($countones(req) == 1));

endmodule

// File: rtl/qm_link_ram.sv
module qm_link_ram #(
  parameter int PTR_W = 6,
  localparam int DEPTH = 1 << PTR_W
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  logic [PTR_W-1:0] wdata,
  input  logic [PTR_W-1:0] raddr,
  output logic [PTR_W-1:0] rdata
);

  logic [PTR_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/qm_queue_table.sv
module qm_queue_table
  import qm_pkg::*;
#(
  parameter int NUM_Q = 16,
  parameter int PTR_W = 6,
  localparam int QID_W = $clog2(NUM_Q),
  localparam int DW    = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  qop_e             op,
  input  logic [QID_W-1:0] qid,
  input  logic [PTR_W-1:0] ptr,
  output logic [DW-1:0]    rd_data,
  output logic             l_we,
  output logic [PTR_W-1:0] l_waddr,
  output logic [PTR_W-1:0] l_wdata,
  output logic [PTR_W-1:0] l_raddr,
  input  logic [PTR_W-1:0] l_rdata
);

  logic [PTR_W-1:0] head_q [NUM_Q];
  logic [PTR_W-1:0] tail_q [NUM_Q];
  logic [PTR_W-1:0] cnt_q  [NUM_Q];

  logic [PTR_W-1:0] hd_sel, tl_sel, cnt_sel;
  logic is_empty, is_full, push_ok;
  logic push_tail_fire, push_head_fire, pop_fire;

  function automatic logic [DW-1:0] status_word(logic [PTR_W-1:0] c);
    return {(c == '0), c};
  endfunction

  assign hd_sel   = head_q[qid];
  assign tl_sel   = tail_q[qid];
  assign cnt_sel  = cnt_q[qid];
  assign is_empty = (cnt_sel == '0);
  assign is_full  = (cnt_sel == '1);
  assign push_ok  = (ptr != '0) && !is_full;

  assign push_tail_fire = (op == QOP_PUSH_TAIL) && push_ok;
  assign push_head_fire = (op == QOP_PUSH_HEAD) && push_ok;
  assign pop_fire       = (op == QOP_POP) && !is_empty;

  always_comb begin
    l_we    = 1'b0;
    l_waddr = tl_sel;
    l_wdata = ptr;
    if (push_tail_fire && !is_empty) begin
      l_we = 1'b1;
    end else if (push_head_fire) begin
      l_we    = 1'b1;
      l_waddr = ptr;
      l_wdata = hd_sel;
    end
  end
  assign l_raddr = hd_sel;

  always_comb begin
    case (op)
      QOP_POP:    rd_data = is_empty ? '0 : DW'(hd_sel);
      QOP_STATUS: rd_data = status_word(cnt_sel);
      default:    rd_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_Q; i++) begin
        head_q[i] <= '0;
        tail_q[i] <= '0;
        cnt_q[i]  <= '0;
      end
    end else if (push_tail_fire) begin
      if (is_empty) head_q[qid] <= ptr;
      tail_q[qid] <= ptr;
      cnt_q[qid]  <= cnt_sel + 1'b1;
    end else if (push_head_fire) begin
      head_q[qid] <= ptr;
      if (is_empty) tail_q[qid] <= ptr;
      cnt_q[qid]  <= cnt_sel + 1'b1;
    end else if (pop_fire) begin
      head_q[qid] <= (cnt_sel == PTR_W'(1)) ? '0 : l_rdata;
      cnt_q[qid]  <= cnt_sel - 1'b1;
    end
  end

  a_r2_tail_takes_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    push_tail_fire |=> tail_q[$past(qid)] == $past(ptr));
  a_r3_head_takes_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    push_head_fire |=> head_q[$past(qid)] == $past(ptr));
  a_r4_pop_nonnull: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |-> rd_data != '0);
  a_r5_empty_pop_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (op == QOP_POP && is_empty) |=> cnt_q[$past(qid)] == '0);
  a_r6_push_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (push_tail_fire || push_head_fire) |=> cnt_q[$past(qid)] == $past(cnt_sel) + 1'b1);
  a_r6_pop_counts: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |=> cnt_q[$past(qid)] == $past(cnt_sel) - 1'b1);
  a_r7_null_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == QOP_PUSH_TAIL || op == QOP_PUSH_HEAD) && ptr == '0)
      |=> cnt_q[$past(qid)] == $past(cnt_sel));

endmodule

// File: rtl/qm_queue_manager.sv
module qm_queue_manager
  import qm_pkg::*;
#(
  parameter int NUM_M = 2,
  parameter int NUM_Q = 16,
  parameter int PTR_W = 6,
  localparam int QID_W  = $clog2(NUM_Q),
  localparam int ADDR_W = QID_W + 2,
  localparam int DATA_W = PTR_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_M-1:0]        m_valid,
  input  logic [NUM_M-1:0]        m_write,
  input  logic [NUM_M*ADDR_W-1:0] m_addr,
  input  logic [NUM_M*PTR_W-1:0]  m_wdata,
  output logic [NUM_M-1:0]        m_ready,
  output logic [NUM_M-1:0]        r_valid,
  output logic [DATA_W-1:0]       r_data
);

  logic [NUM_M-1:0]  gnt;
  logic              g_vld, g_wr;
  logic [ADDR_W-1:0] g_addr;
  logic [PTR_W-1:0]  g_ptr;
  qop_e              g_op;
  logic [QID_W-1:0]  g_qid;
  logic [DATA_W-1:0] tbl_rd;
  logic              l_we;
  logic [PTR_W-1:0]  l_waddr, l_wdata, l_raddr, l_rdata;
  logic [NUM_M-1:0]  rv_q;
  logic [DATA_W-1:0] rd_q;

  qm_rr_arbiter #(.N(NUM_M)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(m_valid), .gnt(gnt)
  );

  always_comb begin
    g_wr   = 1'b0;
    g_addr = '0;
    g_ptr  = '0;
    for (int i = 0; i < NUM_M; i++) begin
      if (gnt[i]) begin
        g_wr   = m_write[i];
        g_addr = m_addr[i*ADDR_W +: ADDR_W];
        g_ptr  = m_wdata[i*PTR_W +: PTR_W];
      end
    end
  end

  assign g_vld = |gnt;
  assign g_op  = qop_decode(g_vld, g_wr, g_addr[1:0]);
  assign g_qid = g_addr[ADDR_W-1:2];

  qm_queue_table #(.NUM_Q(NUM_Q), .PTR_W(PTR_W)) u_tbl (
    .clk(clk), .rst_n(rst_n), .op(g_op), .qid(g_qid), .ptr(g_ptr),
    .rd_data(tbl_rd), .l_we(l_we), .l_waddr(l_waddr), .l_wdata(l_wdata),
    .l_raddr(l_raddr), .l_rdata(l_rdata)
  );

  qm_link_ram #(.PTR_W(PTR_W)) u_link (
    .clk(clk), .we(l_we), .waddr(l_waddr), .wdata(l_wdata),
    .raddr(l_raddr), .rdata(l_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= '0;
      rd_q <= '0;
    end else begin
      rv_q <= qop_is_read(g_op) ? gnt : '0;
      rd_q <= tbl_rd;
    end
  end

  assign m_ready = gnt;
  assign r_valid = rv_q;
  assign r_data  = rd_q;

  a_r8_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (m_ready & ~m_valid) == '0);
  a_r4_read_answers_next: assert property (@(posedge clk) disable iff (!rst_n)
    (|(m_ready & ~m_write)) |=> r_valid == $past(m_ready & ~m_write));
  a_r8_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|(m_ready & ~m_write))) |=> r_valid == '0);
  a_r5_empty_pop_null: assert property (@(posedge clk) disable iff (!rst_n)
    (g_op == QOP_POP && tbl_rd == '0) |=> r_data == '0);

endmodule

// File: tb/qm_queue_manager_test.sv
module qm_queue_manager_test;
  localparam int NM = 2, NQ = 16, PW = 6, QW = 4, AW = 6, DW = 7;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic [NM-1:0]    m_valid, m_write;
  logic [NM*AW-1:0] m_addr;
  logic [NM*PW-1:0] m_wdata;
  wire  [NM-1:0]    m_ready, r_valid;
  wire  [DW-1:0]    r_data;

  int n_vec = 0, n_bad = 0;
  int mq [NQ][$];
  int exp_d [NM][$];
  string exp_t [NM][$];
  int pool [$];
  int last_gnt = -1;

  qm_queue_manager #(.NUM_M(NM), .NUM_Q(NQ), .PTR_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_write(m_write),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_ready(m_ready),
    .r_valid(r_valid), .r_data(r_data)
  );

  task automatic check(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  // reference model, applied at the moment of acceptance
  task automatic model(int m, bit wr, int q, int sel, int ptr, string tag);
    int e;
    if (wr) begin
      if (sel == 0 && ptr != 0) mq[q].push_back(ptr);
      else if (sel == 1 && ptr != 0) mq[q].push_front(ptr);
    end else begin
      e = 0;
      if (sel == 1) begin
        if (mq[q].size() != 0) begin
          e = mq[q].pop_front();
          pool.push_back(e);
        end
      end else if (sel == 2) begin
        e = ((mq[q].size() == 0) ? (1 << PW) : 0) | mq[q].size();
      end
      exp_d[m].push_back(e);
      exp_t[m].push_back(tag);
    end
  endtask

  task automatic issue(int m, bit wr, int q, int sel, int ptr, string tag);
    int other;
    m_valid[m] = 1'b1;
    m_write[m] = wr;
    m_addr[m*AW +: AW]  = {q[QW-1:0], sel[1:0]};
    m_wdata[m*PW +: PW] = ptr[PW-1:0];
    #1;
    while (!m_ready[m]) begin
      @(negedge clk);
      #1;
    end
    other = 1 - m;
    if (m_valid[other]) check("R9 round-robin turn", (last_gnt == m) ? 1 : 0, 0);
    last_gnt = m;
    model(m, wr, q, sel, ptr, tag);
    @(negedge clk);
    m_valid[m] = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      for (int m = 0; m < NM; m++) begin
        if (r_valid[m]) begin
          if (exp_d[m].size() == 0) begin
            check("R8 unexpected response", 1, 0);
          end else begin
            check(exp_t[m].pop_front(), int'(r_data), exp_d[m].pop_front());
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  task automatic random_run(int m, int seed_ops);
    for (int k = 0; k < seed_ops; k++) begin
      int r, q, p;
      r = int'($urandom % 5);
      q = int'($urandom % 4);
      if ((r == 0 || r == 1) && pool.size() > 0) begin
        p = pool.pop_front();
        issue(m, 1'b1, q, r, p, "R8 random push");
      end else if (r == 3) begin
        issue(m, 1'b0, q, 2, 0, "R6 random status");
      end else begin
        issue(m, 1'b0, q, 1, 0, "R4 random pop");
      end
    end
  endtask

  initial begin
    int a, b, c;
    rst_n = 1'b0; m_valid = '0; m_write = '0; m_addr = '0; m_wdata = '0;
    for (int i = 1; i < (1 << PW); i++) pool.push_back(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 r_valid after reset", int'(r_valid), 0);
    check("R11 m_ready idle", int'(m_ready), 0);
    for (int q = 0; q < NQ; q++) issue(0, 1'b0, q, 2, 0, "R11 reset status");

    issue(0, 1'b0, 5, 1, 0, "R5 pop empty");
    issue(0, 1'b0, 5, 2, 0, "R5 status after empty pop");

    a = pool.pop_front(); b = pool.pop_front(); c = pool.pop_front();
    issue(0, 1'b1, 3, 0, a, "R2");
    issue(0, 1'b1, 3, 0, b, "R2");
    issue(0, 1'b1, 3, 0, c, "R2");
    issue(0, 1'b0, 3, 2, 0, "R6 count three");
    for (int i = 0; i < 3; i++) issue(0, 1'b0, 3, 1, 0, "R2 fifo pop");
    issue(0, 1'b0, 3, 2, 0, "R6 empty again");

    a = pool.pop_front(); b = pool.pop_front(); c = pool.pop_front();
    issue(1, 1'b1, 7, 1, a, "R3");
    issue(1, 1'b1, 7, 1, b, "R3");
    issue(1, 1'b1, 7, 1, c, "R3");
    for (int i = 0; i < 3; i++) issue(1, 1'b0, 7, 1, 0, "R3 lifo pop");

    a = pool.pop_front(); b = pool.pop_front(); c = pool.pop_front();
    issue(0, 1'b1, 9, 0, a, "R4");
    issue(0, 1'b1, 9, 1, b, "R4");
    issue(0, 1'b1, 9, 0, c, "R4");
    for (int i = 0; i < 4; i++) issue(0, 1'b0, 9, 1, 0, "R4 mixed pop");

    issue(0, 1'b1, 2, 0, 0, "R7");
    issue(0, 1'b1, 2, 1, 0, "R7");
    issue(0, 1'b0, 2, 2, 0, "R7 null push ignored");
    issue(0, 1'b0, 2, 1, 0, "R7 pop after null push");

    a = pool.pop_front();
    issue(0, 1'b1, 1, 0, a, "R1");
    issue(0, 1'b1, 1, 2, 17, "R1 write status ignored");
    issue(0, 1'b1, 1, 3, 18, "R1 write select3 ignored");
    issue(0, 1'b0, 1, 0, 0, "R1 read tail gives 0");
    issue(0, 1'b0, 1, 3, 0, "R1 read select3 gives 0");
    issue(0, 1'b0, 1, 2, 0, "R1 status unchanged");

    a = pool.pop_front(); b = pool.pop_front();
    issue(1, 1'b1, 0, 0, a, "R10");
    issue(1, 1'b1, 15, 0, b, "R10");
    issue(1, 1'b0, 0, 2, 0, "R10 status q0");
    issue(1, 1'b0, 14, 2, 0, "R10 status q14 untouched");
    issue(1, 1'b0, 15, 1, 0, "R10 pop q15");
    issue(1, 1'b0, 0, 1, 0, "R10 pop q0");
    issue(1, 1'b0, 1, 1, 0, "R10 pop q1");

    fork
      for (int i = 0; i < 6; i++) issue(0, 1'b0, 4, 2, 0, "R8 contention status");
      for (int i = 0; i < 6; i++) issue(1, 1'b0, 4, 2, 0, "R8 contention status");
    join

    fork
      random_run(0, 150);
      random_run(1, 150);
    join

    for (int q = 0; q < 4; q++) begin
      int n;
      n = mq[q].size();
      for (int i = 0; i <= n; i++) issue(0, 1'b0, q, 1, 0, "R4 drain pop");
      issue(0, 1'b0, q, 2, 0, "R6 drained status");
    end

    repeat (3) @(negedge clk);
    check("R8 responses outstanding m0", exp_d[0].size(), 0);
    check("R8 responses outstanding m1", exp_d[1].size(), 0);
    summary();
    $finish;
  end

endmodule